// File: doc/BRIEF.md
# Fault-Injectable Single-Bit RAM

This block is a single-bit-wide RAM of parameterised depth. It exists to be a target for march test engines. Besides the normal address, write enable, read enable and data pins, it has a fault configuration port. That port selects one functional fault class and gives a victim address, an aggressor address and two polarity bits. The block then corrupts every access the way that fault class would in a real cell array. This lets a test engine be shown to catch, or to miss, each class.

The covered classes are:

- faults confined to one cell: stuck-at, transition, stuck-open with a latching sense amplifier, and data retention;
- coupling faults between two cells: inversion, idempotent and state coupling;
- address decoder faults: an address that reaches no cell, a cell that no address reaches, an address that reaches two cells, and a cell that two addresses reach.

Type code zero gives a fault-free memory. The configuration is taken only in cycles with no access, so a fault never changes in the middle of an operation.

Top module: `flt_sram`

## Requirements
- R1: After reset every cell reads 0 and the fault type is none (code 0).
- R2: With code 0, a read returns the last value written to that address. rdata updates on the clock edge that samples rd_en, and otherwise holds its value.
- R3: The configuration inputs are registered only in cycles where wr_en and rd_en are both low. Values presented during busy cycles have no effect.
- R4: Code 1 (stuck-at): any read of the victim address returns pol[0], whatever was written.
- R5: Code 2 (transition): pol[0]=1 makes a 0→1 write to the victim fail, and pol[1]=1 makes a 1→0 write fail. The two directions are independent, and a write that is not blocked works normally.
- R6: Code 3 (stuck-open): a read of the victim leaves rdata at the value of the previous read, and writes to the victim are lost.
- R7: Code 4 (inversion coupling): a write to the aggressor that makes it go 0→1 (pol[0]=0) or 1→0 (pol[0]=1) inverts the victim cell. A transition in the other direction does nothing to the victim.
- R8: Code 5 (idempotent coupling): the same trigger as R7 forces the victim cell to pol[1]. This gives four variants.
- R9: Code 6 (state coupling): while the aggressor cell holds pol[0], reads of the victim return pol[1]. The stored victim value is untouched and reappears once the aggressor changes.
- R10: Code 7 (retention): with pol=01 a stored 1 becomes 0, and with pol=10 a stored 0 becomes 1. The flip happens on the edge RET_LIMIT+1 cycles after the last write to the victim or after the configuration change. With pol=11 the victim behaves as in R6.
- R11: Code 8: a read of the victim address returns pol[0] and a write to it reaches no cell. Code 9: the victim address reaches the aggressor cell, so the victim cell is unreachable.
- R12: Code 10: the victim address reaches both the victim and the aggressor cells; a write updates both, and a read returns their AND. Code 11: the aggressor address reaches the victim cell instead of its own cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Access address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 1 | Write data |
| rdata | output | 1 | Registered read data |
| cfg_type | input | 4 | Fault class code (0 = none, 12–15 treated as none) |
| cfg_victim | input | ADDR_W | Victim address |
| cfg_aggr | input | ADDR_W | Aggressor address |
| cfg_pol | input | 2 | Polarity / trigger / variant bits |

## Verification
The assertions assume three things about the inputs:

- the victim and aggressor addresses differ;
- no read and write land in the same cycle;
- the configuration inputs are only meant to change in idle cycles.

The R3 check is the one place where the configuration moves during busy cycles, and it is built to show that such changes are ignored. The bench keeps to these rules by always using distinct victim and aggressor addresses and by separating accesses with idle cycles. It performs every fault setup through a fault-free fill before the fault is armed. Expected values come from a small model in the bench that follows the requirement text.

// File: rtl/flt_sram_pkg.sv
package flt_sram_pkg;

  typedef enum logic [3:0] {
    FT_NONE   = 4'd0,
    FT_STUCK  = 4'd1,
    FT_TRANS  = 4'd2,
    FT_OPEN   = 4'd3,
    FT_INV    = 4'd4,
    FT_IDEM   = 4'd5,
    FT_STATE  = 4'd6,
    FT_RETAIN = 4'd7,
    FT_NOCELL = 4'd8,
    FT_REMAP  = 4'd9,
    FT_MULTI  = 4'd10,
    FT_ALIAS  = 4'd11
  } fault_e;

  localparam int unsigned FT_LAST = 11;

  // A write old->new to the victim is lost under a transition fault
  function automatic logic trans_blocked(input logic [1:0] pol, input logic old_v,
                                         input logic new_v);
    return (pol[0] & ~old_v & new_v) | (pol[1] & old_v & ~new_v);
  endfunction

  // Retention: value v is the one that leaks away for this polarity
  function automatic logic decays(input logic [1:0] pol, input logic v);
    return ((pol == 2'b01) && v) || ((pol == 2'b10) && !v);
  endfunction

  // Both retention variants at once: cell looks stuck-open
  function automatic logic acts_open(input fault_e t, input logic [1:0] pol);
    return (t == FT_OPEN) || ((t == FT_RETAIN) && (pol == 2'b11));
  endfunction

  // Coupling trigger: pol0=0 rising aggressor, pol0=1 falling aggressor
  function automatic logic coupling_trig(input logic pol0, input logic up, input logic down);
    return pol0 ? down : up;
  endfunction

endpackage

// File: rtl/flt_sram_cfg.sv
module flt_sram_cfg
  import flt_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [3:0]        in_type,
  input  logic [ADDR_W-1:0] in_victim,
  input  logic [ADDR_W-1:0] in_aggr,
  input  logic [1:0]        in_pol,
  output fault_e            type_q,
  output logic [ADDR_W-1:0] victim_q,
  output logic [ADDR_W-1:0] aggr_q,
  output logic [1:0]        pol_q,
  output logic              cfg_take
);

  fault_e type_in;

  always_comb begin
    if (in_type > 4'(FT_LAST)) type_in = FT_NONE;
    else                       type_in = fault_e'(in_type);
  end

  assign cfg_take = !busy && ((type_in != type_q) || (in_victim != victim_q) ||
                              (in_aggr != aggr_q) || (in_pol != pol_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q   <= FT_NONE;
      victim_q <= '0;
      aggr_q   <= '0;
      pol_q    <= '0;
    end else if (cfg_take) begin
      type_q   <= type_in;
      victim_q <= in_victim;
      aggr_q   <= in_aggr;
      pol_q    <= in_pol;
    end
  end

endmodule

// File: rtl/flt_sram_decode.sv
module flt_sram_decode
  import flt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  fault_e            flt_type,
  input  logic [ADDR_W-1:0] victim,
  input  logic [ADDR_W-1:0] aggr,
  output logic [DEPTH-1:0]  reach
);

  logic at_v, at_g;
  assign at_v = (addr == victim);
  assign at_g = (addr == aggr);

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic own, is_v, is_g;
    assign own  = (addr == IDX);
    assign is_v = (victim == IDX);
    assign is_g = (aggr == IDX);

    always_comb begin
      unique case (flt_type)
        FT_NOCELL: reach[i] = own && !at_v;
        FT_REMAP:  reach[i] = (own && !at_v) || (at_v && is_g);
        FT_MULTI:  reach[i] = own || (at_v && is_g);
        FT_ALIAS:  reach[i] = (own && !at_g) || (at_g && is_v);
        default:   reach[i] = own;
      endcase
    end
  end

endmodule

// File: rtl/flt_sram_retain.sv
module flt_sram_retain
  import flt_sram_pkg::*;
#(
  parameter int RET_LIMIT = 24,
  localparam int CNT_W = $clog2(RET_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  fault_e     flt_type,
  input  logic [1:0] pol,
  input  logic       cell_v,
  output logic       decay_fire
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RET_LIMIT);

  logic [CNT_W-1:0] idle_cnt;
  logic             armed;

  assign armed      = (flt_type == FT_RETAIN) && (pol == 2'b01 || pol == 2'b10);
  assign decay_fire = armed && (idle_cnt == LIMIT) && decays(pol, cell_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (clear)             idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

endmodule

// File: rtl/flt_sram_array.sv
module flt_sram_array
  import flt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wdata,
  input  logic [DEPTH-1:0]  reach,
  input  fault_e            flt_type,
  input  logic [ADDR_W-1:0] victim,
  input  logic [ADDR_W-1:0] aggr,
  input  logic [1:0]        pol,
  input  logic              decay_fire,
  output logic [DEPTH-1:0]  cells,
  output logic              victim_wr,
  output logic              aggr_up,
  output logic              aggr_down
);

  logic [DEPTH-1:0] cells_nx;
  logic             couple_evt;

  assign victim_wr  = wr_en && reach[victim];
  assign aggr_up    = wr_en && reach[aggr] && !cells[aggr] && wdata;
  assign aggr_down  = wr_en && reach[aggr] && cells[aggr] && !wdata;
  assign couple_evt = ((flt_type == FT_INV) || (flt_type == FT_IDEM)) &&
                      coupling_trig(pol[0], aggr_up, aggr_down);

  always_comb begin
    cells_nx = cells;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && reach[i]) cells_nx[i] = wdata;
    end
    if (victim_wr) begin
      if ((flt_type == FT_STUCK) || acts_open(flt_type, pol))
        cells_nx[victim] = cells[victim];
      else if ((flt_type == FT_TRANS) && trans_blocked(pol, cells[victim], wdata))
        cells_nx[victim] = cells[victim];
    end
    if (couple_evt) begin
      if (flt_type == FT_INV) cells_nx[victim] = ~cells[victim];
      else                    cells_nx[victim] = pol[1];
    end
    if (decay_fire && !victim_wr) cells_nx[victim] = ~cells[victim];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= cells_nx;
  end

endmodule

// File: rtl/flt_sram.sv
module flt_sram
  import flt_sram_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RET_LIMIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wdata,
  output logic              rdata,
  input  logic [3:0]        cfg_type,
  input  logic [ADDR_W-1:0] cfg_victim,
  input  logic [ADDR_W-1:0] cfg_aggr,
  input  logic [1:0]        cfg_pol
);

  localparam int DEPTH = 1 << ADDR_W;

  fault_e            type_q;
  logic [ADDR_W-1:0] victim_q, aggr_q;
  logic [1:0]        pol_q;
  logic              cfg_take;
  logic [DEPTH-1:0]  reach, cells, eff;
  logic              victim_wr, aggr_up, aggr_down, decay_fire;
  logic              rd_hold, rd_val;

  flt_sram_cfg #(.ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .busy(wr_en || rd_en),
    .in_type(cfg_type), .in_victim(cfg_victim), .in_aggr(cfg_aggr), .in_pol(cfg_pol),
    .type_q(type_q), .victim_q(victim_q), .aggr_q(aggr_q), .pol_q(pol_q),
    .cfg_take(cfg_take)
  );

  flt_sram_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(addr), .flt_type(type_q), .victim(victim_q), .aggr(aggr_q), .reach(reach)
  );

  flt_sram_retain #(.RET_LIMIT(RET_LIMIT)) ret_i (
    .clk(clk), .rst_n(rst_n), .clear(victim_wr || cfg_take),
    .flt_type(type_q), .pol(pol_q), .cell_v(cells[victim_q]), .decay_fire(decay_fire)
  );

  flt_sram_array #(.ADDR_W(ADDR_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .reach(reach),
    .flt_type(type_q), .victim(victim_q), .aggr(aggr_q), .pol(pol_q),
    .decay_fire(decay_fire), .cells(cells), .victim_wr(victim_wr),
    .aggr_up(aggr_up), .aggr_down(aggr_down)
  );

  // Value each cell presents to the sense path
  always_comb begin
    eff = cells;
    if (type_q == FT_STUCK)
      eff[victim_q] = pol_q[0];
    else if ((type_q == FT_STATE) && (cells[aggr_q] == pol_q[0]))
      eff[victim_q] = pol_q[1];
  end

  assign rd_hold = acts_open(type_q, pol_q) && reach[victim_q];
  assign rd_val  = (|reach) ? &(eff | ~reach) : pol_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata <= 1'b0;
    else if (rd_en && !rd_hold) rdata <= rd_val;
  end

endmodule

// File: rtl/flt_sram_checker.sv
module flt_sram_checker
  import flt_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wdata,
  input logic              rdata,
  input fault_e            type_q,
  input logic [ADDR_W-1:0] victim_q,
  input logic [1:0]        pol_q,
  input logic [DEPTH-1:0]  cells,
  input logic              cfg_take,
  input logic              victim_wr,
  input logic              decay_fire
);

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> ($stable(type_q) && $stable(victim_q) && $stable(pol_q))); // R3

  AST_PLAIN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && type_q == FT_NONE) |=> (cells[$past(addr)] == $past(wdata))); // R2

  AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && type_q == FT_STUCK && addr == victim_q) |=> (rdata == pol_q[0])); // R4

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && type_q == FT_OPEN && addr == victim_q) |=> $stable(rdata)); // R6

  AST_DECAY_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (decay_fire && !victim_wr && !cfg_take) |=> (cells[victim_q] != $past(cells[victim_q]))); // R10

  AST_NOCELL_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && type_q == FT_NOCELL && addr == victim_q) |=> (rdata == pol_q[0])); // R11

endmodule

bind flt_sram flt_sram_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .type_q(type_q), .victim_q(victim_q),
  .pol_q(pol_q), .cells(cells), .cfg_take(cfg_take), .victim_wr(victim_wr),
  .decay_fire(decay_fire)
);

// File: tb/flt_sram_tb.sv
module flt_sram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int N          = 1 << AW;
  localparam int RLIM       = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, wdata = 1'b0;
  logic          rdata;
  logic [3:0]    cfg_type = 4'd0;
  logic [AW-1:0] cfg_victim = '0, cfg_aggr = '0;
  logic [1:0]    cfg_pol = 2'b00;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flt_sram #(.ADDR_W(AW), .RET_LIMIT(RLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cfg_type(cfg_type), .cfg_victim(cfg_victim),
    .cfg_aggr(cfg_aggr), .cfg_pol(cfg_pol)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic q);
    @(negedge clk); addr = AW'(a); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic set_cfg(input int t, input int v, input int g, input logic [1:0] p);
    @(negedge clk);
    cfg_type = 4'(t); cfg_victim = AW'(v); cfg_aggr = AW'(g); cfg_pol = p;
    @(negedge clk);
  endtask

  task automatic fill(input logic d);
    set_cfg(0, 0, 0, 2'b00);
    for (int a = 0; a < N; a++) wr(a, d);
  endtask

  function automatic logic pat(input int a, input int k);
    return logic'(((a ^ (a >> 2)) + k) & 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < N; a++) begin
      rd(a, q); chk("R1", $sformatf("reset read a=%0d", a), q, 1'b0);
    end

    // R2: fault-free sweeps, two complementary patterns
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < N; a++) wr(a, pat(a, k));
      for (int a = 0; a < N; a++) begin
        rd(a, q); chk("R2", $sformatf("sweep k=%0d a=%0d", k, a), q, pat(a, k));
      end
    end

    // R3: config presented only during busy cycles is ignored
    fill(1'b0);
    @(negedge clk);
    addr = AW'(5); rd_en = 1'b1;
    cfg_type = 4'd1; cfg_victim = AW'(5); cfg_pol = 2'b01;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); chk("R3", "busy cfg stuck1", rdata, 1'b0);
    end
    rd_en = 1'b0; cfg_type = 4'd0; cfg_victim = '0; cfg_pol = 2'b00;
    @(negedge clk);
    rd(5, q); chk("R3", "after busy cfg", q, 1'b0);

    // R4: stuck-at both polarities
    for (int p = 0; p < 2; p++) begin
      fill(logic'(p == 0));
      set_cfg(1, 5, 0, {1'b0, logic'(p)});
      wr(5, logic'(p == 0));
      rd(5, q); chk("R4", $sformatf("stuck victim p=%0d", p), q, logic'(p));
      rd(4, q); chk("R4", $sformatf("neighbour p=%0d", p), q, logic'(p == 0));
    end

    // R5: transition faults, each direction alone
    fill(1'b0);
    set_cfg(2, 6, 0, 2'b01);
    wr(6, 1'b1); rd(6, q); chk("R5", "up blocked", q, 1'b0);
    set_cfg(2, 6, 0, 2'b10);
    wr(6, 1'b1); rd(6, q); chk("R5", "up allowed", q, 1'b1);
    wr(6, 1'b0); rd(6, q); chk("R5", "down blocked", q, 1'b1);
    set_cfg(2, 6, 0, 2'b01);
    wr(6, 1'b0); rd(6, q); chk("R5", "down allowed", q, 1'b0);

    // R6: stuck-open returns previous read
    fill(1'b0);
    wr(7, 1'b1);
    set_cfg(3, 3, 0, 2'b00);
    rd(7, q); rd(3, q); chk("R6", "open after 1", q, 1'b1);
    rd(8, q); rd(3, q); chk("R6", "open after 0", q, 1'b0);
    wr(3, 1'b1);
    set_cfg(0, 0, 0, 2'b00);
    rd(3, q); chk("R6", "open write lost", q, 1'b0);

    // R7: inversion coupling, both triggers
    for (int t = 0; t < 2; t++) begin
      fill(1'b0);
      wr(2, logic'(t));
      set_cfg(4, 9, 2, {1'b0, logic'(t)});
      wr(2, logic'(t == 0)); rd(9, q); chk("R7", $sformatf("inv t=%0d first", t), q, 1'b1);
      wr(2, logic'(t));      rd(9, q); chk("R7", $sformatf("inv t=%0d other edge", t), q, 1'b1);
      wr(2, logic'(t == 0)); rd(9, q); chk("R7", $sformatf("inv t=%0d second", t), q, 1'b0);
    end

    // R8: idempotent coupling, four variants
    for (int t = 0; t < 2; t++) begin
      for (int f = 0; f < 2; f++) begin
        fill(1'b0);
        wr(2, logic'(t)); wr(9, logic'(f == 0));
        set_cfg(5, 9, 2, {logic'(f), logic'(t)});
        wr(2, logic'(t == 0)); rd(9, q);
        chk("R8", $sformatf("idem t=%0d f=%0d forced", t, f), q, logic'(f));
        wr(9, logic'(f == 0)); wr(2, logic'(t)); rd(9, q);
        chk("R8", $sformatf("idem t=%0d f=%0d other edge", t, f), q, logic'(f == 0));
      end
    end

    // R9: state coupling, four (y,x) combinations
    for (int y = 0; y < 2; y++) begin
      for (int x = 0; x < 2; x++) begin
        fill(1'b0);
        wr(9, logic'(x == 0)); wr(2, logic'(y));
        set_cfg(6, 9, 2, {logic'(x), logic'(y)});
        rd(9, q); chk("R9", $sformatf("state y=%0d x=%0d forced", y, x), q, logic'(x));
        wr(2, logic'(y == 0)); rd(9, q);
        chk("R9", $sformatf("state y=%0d x=%0d released", y, x), q, logic'(x == 0));
      end
    end

    // R10: retention, each variant, then both
    for (int p = 0; p < 2; p++) begin
      fill(1'b0);
      set_cfg(7, 6, 0, (p == 0) ? 2'b01 : 2'b10);
      wr(6, logic'(p == 0)); rd(6, q);
      chk("R10", $sformatf("retain p=%0d fresh", p), q, logic'(p == 0));
      repeat (2 * RLIM) @(negedge clk);
      rd(6, q); chk("R10", $sformatf("retain p=%0d decayed", p), q, logic'(p));
      wr(6, logic'(p)); repeat (2 * RLIM) @(negedge clk);
      rd(6, q); chk("R10", $sformatf("retain p=%0d stable value", p), q, logic'(p));
    end
    fill(1'b0);
    wr(7, 1'b1);
    set_cfg(7, 6, 0, 2'b11);
    rd(7, q); rd(6, q); chk("R10", "both variants act open", q, 1'b1);

    // R11: address reaches no cell; cell unreachable
    fill(1'b1);
    set_cfg(8, 9, 2, 2'b00);
    rd(9, q); chk("R11", "nocell const", q, 1'b0);
    wr(9, 1'b0); rd(8, q); chk("R11", "nocell neighbour", q, 1'b1);
    set_cfg(0, 0, 0, 2'b00);
    rd(9, q); chk("R11", "nocell write lost", q, 1'b1);
    fill(1'b0);
    set_cfg(9, 9, 2, 2'b00);
    wr(9, 1'b1); rd(2, q); chk("R11", "remap lands aggr", q, 1'b1);
    set_cfg(0, 0, 0, 2'b00);
    rd(9, q); chk("R11", "remap victim untouched", q, 1'b0);

    // R12: multi-cell address; shared cell
    fill(1'b0);
    set_cfg(10, 9, 2, 2'b00);
    wr(9, 1'b1); rd(2, q); chk("R12", "multi write both", q, 1'b1);
    wr(2, 1'b0); rd(9, q); chk("R12", "multi wired and", q, 1'b0);
    set_cfg(0, 0, 0, 2'b00);
    rd(9, q); chk("R12", "multi victim cell", q, 1'b1);
    fill(1'b0);
    set_cfg(11, 9, 2, 2'b00);
    wr(2, 1'b1); rd(9, q); chk("R12", "alias reaches victim", q, 1'b1);
    set_cfg(0, 0, 0, 2'b00);
    rd(2, q); chk("R12", "alias aggr cell untouched", q, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule